// File: doc/BRIEF.md
# Enhanced parallel port data-cycle engine

This block runs the host side of a parallel port in its enhanced, handshaked data mode. A small register window with a three-bit offset and read and write strobes holds a data register, a status register and a control register. When enhanced mode is enabled, four further offsets each start one data transfer on the parallel bus. The engine asserts a data strobe, shows the direction on an active-low write line, and waits for the peripheral to raise its wait line. It then releases the strobe and completes the host access. The host access is held off through a ready signal for as long as the transfer runs.

A watchdog limits how long the strobe may stay asserted. When it expires, the transfer is aborted, a sticky timeout flag is set, and a read returns all ones. When no transfer is running, the port behaves as a plain or bidirectional parallel port. The data register drives the bus unless the direction bit turns the bus into an input, and three control bits appear directly on the strobe, auto-feed and init outputs.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, dStb is 0, wrN is 1, pdOutEn is 1, strobeOut, autoFdOut and initOut are 0, and status offset 1 reads 0x00.
- R2: Offset 0 writes the data register, which drives pdOut while no transfer runs and the direction bit is 0. Offset 2 writes the control register: bit 0 drives strobeOut, bit 1 drives autoFdOut, bit 2 drives initOut and bit 5 is the direction bit. Offset 2 reads back the same bits. Register accesses complete with hostReady high in the same cycle.
- R3: With direction bit 5 set and no transfer running, pdOutEn is 0 and a read of offset 0 returns pdIn.
- R4: With eppMode at 1, a read or write at offsets 4 to 7 asserts dStb in the next cycle. hostReady stays 0 while dStb is high.
- R5: A write transfer with direction 0 and control bit 0 clear holds wrN at 0, pdOutEn at 1 and pdOut equal to the host write data while dStb is high.
- R6: A read transfer holds wrN at 1 and pdOutEn at 0. It returns the pdIn value present on the clock edge at which dStb falls, and later changes of pdIn do not alter that value.
- R7: Once nWait is sampled high during a transfer, dStb falls in the next cycle and hostReady is 1 for that one cycle.
- R8: If nWait stays low, dStb stays high for exactly TIMEOUT_CYC cycles (CLK_MHZ x 10, that is 10 us). The transfer then ends, status bit 0 is set, and a read transfer returns 0xFF.
- R9: Status bit 0 stays set until the host writes a 1 to bit 0 of offset 1. Writing 0 there leaves it set.
- R10: While control bit 0 is set, every transfer drives the bus: wrN is 0 and pdOutEn is 1 while dStb is high, even for a read.
- R11: A write transfer requested with direction bit 5 set runs as a read on the bus (wrN 1, pdOutEn 0) and does not set status bit 0.
- R12: With eppMode at 0, an access at offsets 4 to 7 completes at once with hostReady 1, starts no transfer, and reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| eppMode | input | 1 | Enables the transfer offsets 4 to 7 |
| hostAddr | input | 3 | Register offset |
| hostWr | input | 1 | Host write request, held until hostReady |
| hostRd | input | 1 | Host read request, held until hostReady |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, valid while hostReady |
| hostReady | output | 1 | Host access completes in this cycle |
| pdIn | input | 8 | Parallel data bus input |
| pdOut | output | 8 | Parallel data bus output |
| pdOutEn | output | 1 | Parallel data bus output enable |
| wrN | output | 1 | Active-low transfer direction (0 = write) |
| dStb | output | 1 | Data strobe, asserted high |
| nWait | input | 1 | Peripheral handshake, high = ready |
| strobeOut | output | 1 | Control bit 0 |
| autoFdOut | output | 1 | Control bit 1 |
| initOut | output | 1 | Control bit 2 |

## Verification
A wrong sequencer state shows at the ports within one cycle. The strobe stays high after nWait rises, or hostReady appears while the strobe is still asserted. A wrong watchdog count shows only at the end of a stalled transfer, as a strobe pulse of the wrong length and a missing or early status flag, up to TIMEOUT_CYC cycles later. A wrong direction resolution shows on wrN and pdOutEn in the first strobe cycle. A bad read latch shows in hostRdata in the ready cycle, which the bench compares against the bus value it drove on the falling strobe edge.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } eppState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;
    logic start;
    logic active;
    logic latch;
    logic timeout;
    logic done;
  } eppCtl_t;

  localparam int CTRL_STB_BIT  = 0;
  localparam int CTRL_AFD_BIT  = 1;
  localparam int CTRL_INIT_BIT = 2;
  localparam int CTRL_DIR_BIT  = 5;

endpackage

// File: rtl/epp_ctrl.sv
module epp_ctrl
  import epp_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    eppReq,
  input  logic    nWait,
  output eppCtl_t ctl
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  eppState_t state;
  logic [CW-1:0] wdCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wdCount <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (eppReq) begin
            state   <= ST_ACTIVE;
            wdCount <= '0;
          end
        end
        ST_ACTIVE: begin
          if (nWait || wdCount == LAST) state <= ST_DONE;
          else wdCount <= wdCount + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.idle    = (state == ST_IDLE);
    ctl.start   = (state == ST_IDLE) && eppReq;
    ctl.active  = (state == ST_ACTIVE);
    ctl.latch   = (state == ST_ACTIVE) && nWait;
    ctl.timeout = (state == ST_ACTIVE) && !nWait && (wdCount == LAST);
    ctl.done    = (state == ST_DONE);
  end

endmodule

// File: rtl/epp_datapath.sv
module epp_datapath
  import epp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  eppCtl_t       ctl,
  input  logic          eppReq,
  input  logic [2:0]    hostAddr,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  input  logic [DW-1:0] pdIn,
  output logic [DW-1:0] pdOut,
  output logic          pdOutEn,
  output logic          wrN,
  output logic          dStb,
  output logic          strobeOut,
  output logic          autoFdOut,
  output logic          initOut
);
  localparam logic [DW-1:0] ALL_ONES = '1;

  logic [DW-1:0] dataReg, cycData, rdLatch;
  logic [DW-1:0] ctrlReg;
  logic          toFlag, cycWrite, regWe, dirBit, stbBit;

  assign dirBit = ctrlReg[CTRL_DIR_BIT];
  assign stbBit = ctrlReg[CTRL_STB_BIT];
  assign regWe  = hostWr && ctl.idle && !eppReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      ctrlReg  <= '0;
      toFlag   <= 1'b0;
      cycData  <= '0;
      cycWrite <= 1'b0;
      rdLatch  <= '0;
    end else begin
      if (regWe) begin
        case (hostAddr)
          3'd0: dataReg <= hostWdata;
          3'd1: if (hostWdata[0]) toFlag <= 1'b0;
          3'd2: begin
            ctrlReg <= '0;
            ctrlReg[CTRL_STB_BIT]  <= hostWdata[CTRL_STB_BIT];
            ctrlReg[CTRL_AFD_BIT]  <= hostWdata[CTRL_AFD_BIT];
            ctrlReg[CTRL_INIT_BIT] <= hostWdata[CTRL_INIT_BIT];
            ctrlReg[CTRL_DIR_BIT]  <= hostWdata[CTRL_DIR_BIT];
          end
          default: ;
        endcase
      end
      if (ctl.start) begin
        cycData  <= hostWdata;
        cycWrite <= hostWr && !dirBit;
      end
      if (ctl.latch)   rdLatch <= pdIn;
      if (ctl.timeout) begin
        rdLatch <= ALL_ONES;
        toFlag  <= 1'b1;
      end
    end
  end

  // parallel-side drive
  always_comb begin
    dStb = ctl.active;
    if (ctl.active) begin
      pdOutEn = cycWrite || stbBit;
      wrN     = !(cycWrite || stbBit);
      pdOut   = cycData;
    end else begin
      pdOutEn = !dirBit;
      wrN     = 1'b1;
      pdOut   = dataReg;
    end
    strobeOut = ctrlReg[CTRL_STB_BIT];
    autoFdOut = ctrlReg[CTRL_AFD_BIT];
    initOut   = ctrlReg[CTRL_INIT_BIT];
  end

  // host read mux
  always_comb begin
    hostRdata = '0;
    if (ctl.done) begin
      hostRdata = rdLatch;
    end else if (hostRd) begin
      case (hostAddr)
        3'd0:    hostRdata = dirBit ? pdIn : dataReg;
        3'd1:    hostRdata = {{(DW-1){1'b0}}, toFlag};
        3'd2:    hostRdata = ctrlReg;
        3'd3:    hostRdata = '0;
        default: hostRdata = ALL_ONES;
      endcase
    end
  end

endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          eppMode,
  input  logic [2:0]    hostAddr,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  output logic          hostReady,
  input  logic [DW-1:0] pdIn,
  output logic [DW-1:0] pdOut,
  output logic          pdOutEn,
  output logic          wrN,
  output logic          dStb,
  input  logic          nWait,
  output logic          strobeOut,
  output logic          autoFdOut,
  output logic          initOut
);
  localparam int TIMEOUT_CYC = CLK_MHZ * 10;

  eppCtl_t ctl;
  logic    eppReq, anyReq;

  assign anyReq    = hostWr || hostRd;
  assign eppReq    = eppMode && hostAddr[2] && anyReq;
  assign hostReady = ctl.done || (ctl.idle && anyReq && !eppReq);

  epp_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .eppReq (eppReq),
    .nWait  (nWait),
    .ctl    (ctl)
  );

  epp_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .eppReq    (eppReq),
    .hostAddr  (hostAddr),
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .pdIn      (pdIn),
    .pdOut     (pdOut),
    .pdOutEn   (pdOutEn),
    .wrN       (wrN),
    .dStb      (dStb),
    .strobeOut (strobeOut),
    .autoFdOut (autoFdOut),
    .initOut   (initOut)
  );

endmodule

// File: rtl/epp_cycle_engine_checker.sv
module epp_cycle_engine_checker #(
  parameter int TIMEOUT_CYC = 500
) (
  input logic clk,
  input logic rstN,
  input logic dStb,
  input logic nWait,
  input logic wrN,
  input logic pdOutEn,
  input logic hostReady
);
  localparam int CW = $clog2(TIMEOUT_CYC + 2);
  logic [CW-1:0] stbRun;

  always_ff @(posedge clk) begin
    if (!rstN) stbRun <= '0;
    else if (dStb) stbRun <= stbRun + 1'b1;
    else stbRun <= '0;
  end

  AST_NO_READY_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN) dStb |-> !hostReady); // R4
  AST_END_ON_WAIT: assert property (@(posedge clk) disable iff (!rstN) (dStb && nWait) |=> (!dStb && hostReady)); // R7
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN) (dStb && !wrN) |-> pdOutEn); // R5
  AST_WRN_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN) !dStb |-> wrN); // R2
  AST_WATCHDOG_LIMIT: assert property (@(posedge clk) disable iff (!rstN) dStb |-> (int'(stbRun) < TIMEOUT_CYC)); // R8

endmodule

bind epp_cycle_engine epp_cycle_engine_checker #(.TIMEOUT_CYC(CLK_MHZ * 10)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dStb      (dStb),
  .nWait     (nWait),
  .wrN       (wrN),
  .pdOutEn   (pdOutEn),
  .hostReady (hostReady)
);

// File: tb/epp_cycle_engine_bench.sv
module epp_cycle_engine_bench;
  localparam int TO = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eppMode = 1'b0;
  logic [2:0] hostAddr = '0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0, pdIn = '0;
  logic nWait = 1'b0;
  logic [7:0] hostRdata, pdOut;
  logic hostReady, pdOutEn, wrN, dStb, strobeOut, autoFdOut, initOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  epp_cycle_engine u_epp_cycle_engine (
    .clk(clk), .rstN(rstN), .eppMode(eppMode), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostReady(hostReady), .pdIn(pdIn),
    .pdOut(pdOut), .pdOutEn(pdOutEn), .wrN(wrN), .dStb(dStb),
    .nWait(nWait), .strobeOut(strobeOut), .autoFdOut(autoFdOut),
    .initOut(initOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit expDrive(input bit isWr, input bit dir, input bit stb);
    return (isWr && !dir) || stb;
  endfunction

  function automatic int expRead(input int stbCyc, input logic [7:0] bus);
    return (stbCyc >= TO) ? 8'hFF : bus;
  endfunction

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d, output bit rdy);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #1;
    d = hostRdata; rdy = hostReady;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  // delay 0 means the peripheral never answers
  task automatic eppAccess(input logic [2:0] a, input bit isWr, input logic [7:0] wd,
                           input int delay, input logic [7:0] bus,
                           output logic [7:0] rd, output int stbCyc,
                           output bit sawWrN, output bit sawOe, output logic [7:0] sawPd,
                           output bit stbAfter);
    stbCyc = 0; sawWrN = 1'b1; sawOe = 1'b0; sawPd = '0;
    @(negedge clk);
    hostAddr = a; hostWr = isWr; hostRd = !isWr; hostWdata = wd; pdIn = bus;
    forever begin
      @(negedge clk);
      if (hostReady) break;
      if (dStb) begin
        stbCyc++;
        sawWrN = wrN; sawOe = pdOutEn; sawPd = pdOut;
        if (stbCyc == delay) nWait = 1'b1;
      end
    end
    rd = hostRdata; stbAfter = dStb;
    pdIn = ~bus; nWait = 1'b0;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, pd;
    int sc;
    bit wn, oe, sa, rdy;
    void'($urandom(32'h1D2C));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dStb", dStb, 0);
    check("R1 wrN", wrN, 1);
    check("R1 pdOutEn", pdOutEn, 1);
    check("R1 ctl outs", {strobeOut, autoFdOut, initOut}, 0);
    regRead(3'd1, rd, rdy);
    check("R1 status", rd, 8'h00);

    // R2 data and control registers
    regWrite(3'd0, 8'h5A);
    check("R2 pdOut", pdOut, 8'h5A);
    check("R2 pdOutEn", pdOutEn, 1);
    regWrite(3'd2, 8'h07);
    check("R2 ctl outs", {strobeOut, autoFdOut, initOut}, 3'b111);
    regRead(3'd2, rd, rdy);
    check("R2 ctrl readback", rd, 8'h07);
    check("R2 ready", rdy, 1);

    // R3 input direction
    regWrite(3'd2, 8'h20);
    check("R3 pdOutEn", pdOutEn, 0);
    pdIn = 8'h3C;
    regRead(3'd0, rd, rdy);
    check("R3 data read", rd, 8'h3C);
    regWrite(3'd2, 8'h00);

    // R12 transfer offsets disabled
    regRead(3'd5, rd, rdy);
    check("R12 ready", rdy, 1);
    check("R12 data", rd, 8'hFF);
    check("R12 no strobe", dStb, 0);

    eppMode = 1'b1;
    // R4 R5 write transfer
    eppAccess(3'd4, 1'b1, 8'hC3, 3, 8'h00, rd, sc, wn, oe, pd, sa);
    check("R4 strobe cycles", sc, 3);
    check("R5 wrN", wn, 0);
    check("R5 pdOutEn", oe, 1);
    check("R5 pdOut", pd, 8'hC3);
    check("R7 strobe released", sa, 0);

    // R6 read transfer and latch hold
    eppAccess(3'd6, 1'b0, 8'h00, 2, 8'hA7, rd, sc, wn, oe, pd, sa);
    check("R6 data", rd, 8'hA7);
    check("R6 wrN", wn, 1);
    check("R6 pdOutEn", oe, 0);

    // R8 watchdog
    eppAccess(3'd7, 1'b0, 8'h00, 0, 8'h11, rd, sc, wn, oe, pd, sa);
    check("R8 strobe length", sc, TO);
    check("R8 read data", rd, 8'hFF);
    regRead(3'd1, rd, rdy);
    check("R8 status", rd, 8'h01);

    // R9 sticky flag
    regWrite(3'd1, 8'h00);
    regRead(3'd1, rd, rdy);
    check("R9 write0 keeps", rd, 8'h01);
    regWrite(3'd1, 8'h01);
    regRead(3'd1, rd, rdy);
    check("R9 write1 clears", rd, 8'h00);

    // R10 strobe bit forces drive
    regWrite(3'd2, 8'h01);
    eppAccess(3'd5, 1'b0, 8'h00, 2, 8'h66, rd, sc, wn, oe, pd, sa);
    check("R10 wrN", wn, 0);
    check("R10 pdOutEn", oe, 1);

    // R11 write with input direction
    regWrite(3'd2, 8'h20);
    eppAccess(3'd4, 1'b1, 8'h99, 2, 8'h44, rd, sc, wn, oe, pd, sa);
    check("R11 wrN", wn, 1);
    check("R11 pdOutEn", oe, 0);
    regRead(3'd1, rd, rdy);
    check("R11 no error", rd, 8'h00);

    // random transfers
    for (int i = 0; i < 24; i++) begin
      logic [7:0] ctrlV, wd, bus;
      bit isWr, dir, stb;
      int dly;
      dir = 1'($urandom_range(0, 1));
      stb = ($urandom_range(0, 3) == 0);
      ctrlV = {2'b00, dir, 4'b0000, stb};
      isWr = 1'($urandom_range(0, 1));
      wd = 8'($urandom);
      bus = 8'($urandom);
      dly = (i % 8 == 5) ? 0 : $urandom_range(1, 6);
      regWrite(3'd2, ctrlV);
      eppAccess(3'(4 + (i % 4)), isWr, wd, dly, bus, rd, sc, wn, oe, pd, sa);
      check("R8 random length", sc, (dly == 0) ? TO : dly);
      check("R10 random wrN", wn, !expDrive(isWr, dir, stb));
      check("R5 random oe", oe, expDrive(isWr, dir, stb));
      if (!isWr) check("R6 random data", rd, expRead(sc, bus));
      regRead(3'd1, rd, rdy);
      check("R9 random status", rd, (dly == 0) ? 1 : 0);
      if (dly == 0) regWrite(3'd1, 8'h01);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule